// File: doc/BRIEF.md
# Masked-Access GPIO Bank Controller

An eight-pin general purpose I/O bank driven from a byte-wide register bus. Each pin has an output level and a direction bit. Software reaches both through address windows that carry an eight-bit pin mask in address bits [9:2]. A single store can therefore set or clear any chosen subset of pins without first reading the register back. A read through the same window returns only the selected pins and zeros in the other positions.

Each pin feeds a two-flop synchronizer and then a per-pin interrupt detector. The detector is configured per pin for level or edge sensing, for active-high/rising or active-low/falling polarity, and for a both-edges mode. Edge events are latched until software acknowledges them through a write-one-to-clear register. Level events follow the synchronized pad. A per-pin enable forms a masked status, and the OR of the masked status drives a single interrupt line. A per-pin alternate-function select register is stored for the pad multiplexer outside the block.

Top module: `gpb_top`

## Requirements
- R1: A write at address (mask<<2) in the data window (address bits [11:10]=00, bits [1:0]=00) changes padOut only in the bits set in mask. A mask of zero changes nothing.
- R2: A read in the data window returns, for each mask bit set, the output latch if that pin is an output (direction bit 1) or the synchronized pad if it is an input (direction bit 0). Unselected bits read 0.
- R3: The direction window is at 0x800 + (mask<<2) and uses the same masked write and read rules. padOe equals the direction register, with 1 meaning output.
- R4: After reset, padOut, padOe and irqOut are 0, and the sense (0x404), both-edge (0x408), polarity (0x40C), enable (0x410), raw (0x414), masked (0x418) and alternate-select (0x420) registers all read 0.
- R5: A pin with its sense bit at 1 is level-sensed. Its raw status is 1 while the synchronized pad equals its polarity bit (1 = high, 0 = low).
- R6: A pin with its sense bit at 0 and its both-edge bit at 0 latches raw status on a rising edge if its polarity bit is 1, and on a falling edge if its polarity bit is 0. The opposite edge does not set it.
- R7: An edge-sensed pin with its both-edge bit at 1 latches on rising and on falling edges, whatever its polarity bit holds.
- R8: A latched edge status stays set until a 1 is written to its bit at 0x41C. Writing 0 to a bit there leaves that pin's status unchanged.
- R9: An edge detected in the same cycle as a clear of that pin leaves the status set.
- R10: Writing the clear register does not remove the status of a level-sensed pin while its level is active.
- R11: The masked status at 0x418 equals raw status AND enable (0x410). irqOut is 1 exactly when any masked status bit is 1.
- R12: The alternate-select register at 0x420 stores and reads back one bit per pin and does not alter padOut or padOe.
- R13: Sense, both-edge, polarity and enable registers read back the value last written at their own offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| padIn | input | 8 | Pad input levels, asynchronous |
| padOut | output | 8 | Pad output levels |
| padOe | output | 8 | Pad output enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge arriving in the very cycle that software clears the same pin. The pad change has to be timed so that the acknowledge store lands on the clock edge where the edge latch would load, two synchronizer stages after the pad moved. The stimulus changes the pad on a falling clock edge, counts two rising edges, and then holds the write strobe across the third. Other corner cases: clears of level-sensed pins, clears written with zero bits, masked writes with an empty mask, and reads that mix input and output pins.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  // Register offsets; software depends on these positions.
  localparam int unsigned OFS_SENSE  = 32'h404;
  localparam int unsigned OFS_BOTH   = 32'h408;
  localparam int unsigned OFS_POL    = 32'h40C;
  localparam int unsigned OFS_EN     = 32'h410;
  localparam int unsigned OFS_RAW    = 32'h414;
  localparam int unsigned OFS_MASKED = 32'h418;
  localparam int unsigned OFS_ACK    = 32'h41C;
  localparam int unsigned OFS_ALT    = 32'h420;

  // Window codes carried by the two address bits above the mask field.
  localparam logic [1:0] WIN_DATA = 2'b00;
  localparam logic [1:0] WIN_CFG  = 2'b01;
  localparam logic [1:0] WIN_DIR  = 2'b10;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH,
    RD_POL, RD_EN, RD_RAW, RD_MASKED, RD_ALT
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrSense;
    logic   wrBoth;
    logic   wrPol;
    logic   wrEn;
    logic   wrAck;
    logic   wrAlt;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpb_ctrl.sv
module gpb_ctrl
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  output strobe_t             strb,
  output logic [NUM_PINS-1:0] pinMask
);

  localparam int MASK_LO  = 2;
  localparam int MASK_HI  = MASK_LO + NUM_PINS - 1;
  localparam int WIN_LO   = MASK_HI + 1;
  localparam int WIN_HI   = WIN_LO + 1;

  logic [1:0] winCode;
  logic       aligned;
  logic       inData;
  logic       inDir;
  logic       highZero;

  assign winCode  = busAddr[WIN_HI:WIN_LO];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign pinMask  = busAddr[MASK_HI:MASK_LO];

  generate
    if (ADDR_W > WIN_HI + 1) begin : gHigh
      assign highZero = (busAddr[ADDR_W-1:WIN_HI+1] == '0);
    end else begin : gNoHigh
      assign highZero = 1'b1;
    end
  endgenerate

  assign inData = highZero && aligned && (winCode == WIN_DATA);
  assign inDir  = highZero && aligned && (winCode == WIN_DIR);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    strb.wrData  = busWe && inData;
    strb.wrDir   = busWe && inDir;
    strb.wrSense = busWe && hit(busAddr, OFS_SENSE);
    strb.wrBoth  = busWe && hit(busAddr, OFS_BOTH);
    strb.wrPol   = busWe && hit(busAddr, OFS_POL);
    strb.wrEn    = busWe && hit(busAddr, OFS_EN);
    strb.wrAck   = busWe && hit(busAddr, OFS_ACK);
    strb.wrAlt   = busWe && hit(busAddr, OFS_ALT);
    if (inData)                         strb.rdSel = RD_DATA;
    else if (inDir)                     strb.rdSel = RD_DIR;
    else if (hit(busAddr, OFS_SENSE))   strb.rdSel = RD_SENSE;
    else if (hit(busAddr, OFS_BOTH))    strb.rdSel = RD_BOTH;
    else if (hit(busAddr, OFS_POL))     strb.rdSel = RD_POL;
    else if (hit(busAddr, OFS_EN))      strb.rdSel = RD_EN;
    else if (hit(busAddr, OFS_RAW))     strb.rdSel = RD_RAW;
    else if (hit(busAddr, OFS_MASKED))  strb.rdSel = RD_MASKED;
    else if (hit(busAddr, OFS_ALT))     strb.rdSel = RD_ALT;
  end

  // At most one register is written per bus cycle (R13).
  assert_onehot_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrData, strb.wrDir, strb.wrSense, strb.wrBoth,
              strb.wrPol, strb.wrEn, strb.wrAck, strb.wrAlt}));

  // A direction write only happens for a write strobe in the direction window (R3).
  assert_dir_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrDir |-> (busWe && busAddr[WIN_HI:WIN_LO] == WIN_DIR));

endmodule

// File: rtl/gpb_pin_sense.sv
module gpb_pin_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic padBit,
  input  logic cfgLevel,
  input  logic cfgBoth,
  input  logic cfgHigh,
  input  logic ackBit,
  output logic syncBit,
  output logic rawBit
);

  logic stage1;
  logic prevBit;
  logic edgeLatch;
  logic riseEv;
  logic fallEv;
  logic edgeHit;
  logic levelHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1  <= 1'b0;
      syncBit <= 1'b0;
      prevBit <= 1'b0;
    end else begin
      stage1  <= padBit;
      syncBit <= stage1;
      prevBit <= syncBit;
    end
  end

  assign riseEv   = syncBit & ~prevBit;
  assign fallEv   = ~syncBit & prevBit;
  assign edgeHit  = ~cfgLevel & (cfgBoth ? (riseEv | fallEv)
                                         : (cfgHigh ? riseEv : fallEv));
  assign levelHit = cfgLevel & (cfgHigh ? syncBit : ~syncBit);

  // A fresh edge outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) edgeLatch <= 1'b0;
    else        edgeLatch <= (edgeLatch & ~ackBit) | edgeHit;
  end

  assign rawBit = cfgLevel ? levelHit : edgeLatch;

  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edgeHit |=> edgeLatch);

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeLatch && !ackBit) |=> edgeLatch);

  assert_level_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLevel && $stable(cfgLevel) && $stable(cfgHigh) && $stable(syncBit) && $past(rawBit))
      |-> rawBit);

endmodule

// File: rtl/gpb_datapath.sv
module gpb_datapath
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  logic [NUM_PINS-1:0] pinMask,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] dataReg;
  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] senseReg;
  logic [NUM_PINS-1:0] bothReg;
  logic [NUM_PINS-1:0] polReg;
  logic [NUM_PINS-1:0] enReg;
  logic [NUM_PINS-1:0] altReg;
  logic [NUM_PINS-1:0] ackVec;
  logic [NUM_PINS-1:0] syncVec;
  logic [NUM_PINS-1:0] rawVec;
  logic [NUM_PINS-1:0] maskedVec;
  logic [NUM_PINS-1:0] pinView;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataReg  <= '0;
      dirReg   <= '0;
      senseReg <= '0;
      bothReg  <= '0;
      polReg   <= '0;
      enReg    <= '0;
      altReg   <= '0;
    end else begin
      if (strb.wrData)  dataReg  <= (dataReg & ~pinMask) | (wdata & pinMask);
      if (strb.wrDir)   dirReg   <= (dirReg & ~pinMask) | (wdata & pinMask);
      if (strb.wrSense) senseReg <= wdata;
      if (strb.wrBoth)  bothReg  <= wdata;
      if (strb.wrPol)   polReg   <= wdata;
      if (strb.wrEn)    enReg    <= wdata;
      if (strb.wrAlt)   altReg   <= wdata;
    end
  end

  assign ackVec = strb.wrAck ? wdata : '0;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
      gpb_pin_sense senseU (
        .clk      (clk),
        .rst_n    (rst_n),
        .padBit   (padIn[i]),
        .cfgLevel (senseReg[i]),
        .cfgBoth  (bothReg[i]),
        .cfgHigh  (polReg[i]),
        .ackBit   (ackVec[i]),
        .syncBit  (syncVec[i]),
        .rawBit   (rawVec[i])
      );
    end
  endgenerate

  assign maskedVec = rawVec & enReg;
  assign irqOut    = |maskedVec;
  assign padOut    = dataReg;
  assign padOe     = dirReg;
  assign pinView   = (dirReg & dataReg) | (~dirReg & syncVec);

  always_comb begin
    unique case (strb.rdSel)
      RD_DATA:   rdData = pinView & pinMask;
      RD_DIR:    rdData = dirReg & pinMask;
      RD_SENSE:  rdData = senseReg;
      RD_BOTH:   rdData = bothReg;
      RD_POL:    rdData = polReg;
      RD_EN:     rdData = enReg;
      RD_RAW:    rdData = rawVec;
      RD_MASKED: rdData = maskedVec;
      RD_ALT:    rdData = altReg;
      default:   rdData = '0;
    endcase
  end

  assert_mask_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrData |=> ((padOut & ~$past(pinMask)) == ($past(padOut) & ~$past(pinMask))));

  assert_dir_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrDir |=> ((padOe & ~$past(pinMask)) == ($past(padOe) & ~$past(pinMask))));

  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enReg == '0) |-> !irqOut);

endmodule

// File: rtl/gpb_top.sv
module gpb_top
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);

  strobe_t             strb;
  logic [NUM_PINS-1:0] pinMask;

  gpb_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) ctrlU (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb),
    .pinMask (pinMask)
  );

  gpb_datapath #(.NUM_PINS(NUM_PINS)) dpU (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .pinMask (pinMask),
    .wdata   (busWdata),
    .padIn   (padIn),
    .rdData  (busRdata),
    .padOut  (padOut),
    .padOe   (padOe),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/gpb_top_tb.sv
module gpb_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut;
  logic [7:0]  padOe;
  logic        irqOut;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gpb_top dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  // {write address, write data, read address, expected read}
  localparam int NVEC = 13;
  localparam logic [39:0] VEC [NVEC] = '{
    {12'hBFC, 8'hFF, 12'hBFC, 8'hFF},   // R3 all outputs
    {12'h3FC, 8'hA5, 12'h3FC, 8'hA5},   // R1 full mask
    {12'h03C, 8'h00, 12'h3FC, 8'hA0},   // R1 low nibble only
    {12'h200, 8'h00, 12'h3FC, 8'h20},   // R1 pin 7 only
    {12'h004, 8'hFF, 12'h004, 8'h01},   // R2 single pin read
    {12'h000, 8'hFF, 12'h3FC, 8'h21},   // R1 empty mask
    {12'h420, 8'h3C, 12'h420, 8'h3C},   // R12
    {12'h404, 8'h81, 12'h404, 8'h81},   // R13
    {12'h408, 8'h42, 12'h408, 8'h42},   // R13
    {12'h40C, 8'h18, 12'h40C, 8'h18},   // R13
    {12'h410, 8'hE7, 12'h410, 8'hE7},   // R13
    {12'h83C, 8'h00, 12'hBFC, 8'hF0},   // R3 masked direction
    {12'h41C, 8'h00, 12'h3FC, 8'h20}    // R2 mixed in/out pins
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #2;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    #2;
    check("R4 padOut", padOut, 8'h00);
    check("R4 padOe", padOe, 8'h00);
    check("R4 irqOut", {7'b0, irqOut}, 8'h00);
    for (int k = 0; k < 8; k++) begin
      busRead(12'h404 + 12'(4 * k), rd);
      check("R4 config reg", rd, 8'h00);
    end

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      busWrite(VEC[v][39:28], VEC[v][27:20]);
      busRead(VEC[v][19:8], rd);
      check("R1/R2/R3/R12/R13 vector", rd, VEC[v][7:0]);
    end
    #2;
    check("R1 padOut after table", padOut, 8'h21);
    check("R3 padOe after table", padOe, 8'hF0);
    check("R12 alt select leaves padOe", padOe, 8'hF0);

    // Clean configuration for interrupt tests
    busWrite(12'h404, 8'h00);
    busWrite(12'h408, 8'h00);
    busWrite(12'h40C, 8'h00);
    busWrite(12'h410, 8'h00);
    busWrite(12'h420, 8'h00);
    busWrite(12'hBFC, 8'h00);
    settle();
    busWrite(12'h41C, 8'hFF);
    busRead(12'h414, rd);
    check("R8 cleared baseline", rd, 8'h00);

    // R6 rising edge on pin 0
    busWrite(12'h40C, 8'h01);
    busWrite(12'h410, 8'h01);
    padIn[0] = 1'b1; settle();
    busRead(12'h414, rd); check("R6 rising latched", rd, 8'h01);
    busRead(12'h418, rd); check("R11 masked status", rd, 8'h01);
    check("R11 irqOut high", {7'b0, irqOut}, 8'h01);
    padIn[0] = 1'b0; settle();
    busRead(12'h414, rd); check("R8 held after pad drop", rd, 8'h01);
    busWrite(12'h41C, 8'h02);
    busRead(12'h414, rd); check("R8 zero bit clear no effect", rd, 8'h01);
    busWrite(12'h41C, 8'h01);
    busRead(12'h414, rd); check("R8 cleared", rd, 8'h00);
    check("R11 irqOut low", {7'b0, irqOut}, 8'h00);

    // R6 falling edge on pin 1 (polarity 0), not enabled
    padIn[1] = 1'b1; settle();
    busRead(12'h414, rd); check("R6 rising ignored at low polarity", rd, 8'h00);
    padIn[1] = 1'b0; settle();
    busRead(12'h414, rd); check("R6 falling latched", rd, 8'h02);
    busRead(12'h418, rd); check("R11 disabled pin masked", rd, 8'h00);
    check("R11 irqOut stays low", {7'b0, irqOut}, 8'h00);
    busWrite(12'h41C, 8'h02);

    // R7 both edges on pin 2, polarity 0
    busWrite(12'h408, 8'h04);
    padIn[2] = 1'b1; settle();
    busRead(12'h414, rd); check("R7 rising in both mode", rd, 8'h04);
    busWrite(12'h41C, 8'h04);
    padIn[2] = 1'b0; settle();
    busRead(12'h414, rd); check("R7 falling in both mode", rd, 8'h04);
    busWrite(12'h41C, 8'h04);
    busWrite(12'h408, 8'h00);

    // R5 / R10 level sensing on pin 3
    busWrite(12'h40C, 8'h09);
    busWrite(12'h404, 8'h08);
    settle();
    busRead(12'h414, rd); check("R5 level high inactive", rd, 8'h00);
    padIn[3] = 1'b1; settle();
    busRead(12'h414, rd); check("R5 level high active", rd, 8'h08);
    busWrite(12'h41C, 8'h08);
    busRead(12'h414, rd); check("R10 level survives clear", rd, 8'h08);
    padIn[3] = 1'b0; settle();
    busRead(12'h414, rd); check("R5 level follows pad", rd, 8'h00);
    busWrite(12'h40C, 8'h01);
    busRead(12'h414, rd); check("R5 level low active", rd, 8'h08);
    busWrite(12'h404, 8'h00);
    busWrite(12'h41C, 8'hFF);
    busRead(12'h414, rd); check("R5 back to edge clear", rd, 8'h00);

    // R9 edge in same cycle as clear, pin 0 rising
    @(negedge clk);
    padIn[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busAddr = 12'h41C; busWdata = 8'h01; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    busRead(12'h414, rd); check("R9 edge beats clear", rd, 8'h01);
    busWrite(12'h41C, 8'h01);
    busRead(12'h414, rd); check("R9 later clear works", rd, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule